// File: doc/BRIEF.md
# Display Controller Power Gating Unit

This block is the power-down controller of a palette and video DAC controller. A processor reaches four control registers through an 8-bit indexed port. It uses them to stop clock domains, to put output drivers into high impedance, to power down the DAC and to force the two sync outputs to fixed levels.

The block turns the stored bits into gated clocks for the internal core logic, the SCLK generator, the dot-clock generator and the sync delay circuits. Each gated clock comes from a latch-based gating cell. The block also produces output enables for the external drivers and a DAC power-down level.

Pixel data bound for the DAC passes through a register that stops loading while the internal-clock inhibit is set. The DAC therefore keeps the last value it was given. The palette access logic runs on the ungated clock, so register access keeps working in every power state.

Top module: `dpwr_gate`

## Requirements
- R1: After reset all four registers read 0. All gated clocks run, all driver enables are 1, `dac_pd` is 0 and `reg_rdata_oe` is 0.
- R2: Writes and reads use these indices: 0x02 for clock-driver control, 0x03 for sync control, 0x05 for power control and 0x70 for misc control. Bits with no defined function read back as 0, and any other index reads 0.
- R3: `reg_rdata_oe` is 1 only in a cycle where `reg_re` is 1, so the processor data bus is otherwise released.
- R4: The power control register has these bits: bit4 powers the DAC down and drives `dac_pd`, bit3 inhibits internal clocking, bit2 stops the sync clock, bit1 stops the dot-clock generator and bit0 stops the SCLK generator.
- R5: The inhibit bit stops only `gclk_core`. `gclk_pal`, `gclk_sclkgen`, `gclk_dotgen` and `gclk_sync` keep running while it is set.
- R6: Each generator stop bit stops only its own gated clock and leaves every other clock running.
- R7: A stopped gated clock rests low. A change to an enable takes effect from the first high phase that follows the write edge, so no pulse is ever shortened.
- R8: While the inhibit is clear, `dac_data` takes the value of `pix_in` at each rising edge. While the inhibit is set, `dac_data` holds the last value it loaded.
- R9: In the clock-driver register, bit0 set drives `sclk_oe` to 0 and bit1 set drives `dotclk_oe` to 0. In the misc register, bit0 set drives `sense_oe` to 0.
- R10: The sync register holds two fields, HSYNC in bits [1:0] and VSYNC in bits [3:2]. The codes are 00 pass the input through, 01 force high, 10 force low and 11 high impedance. In the high-impedance case the output enable is 0 and the output value is 0.
- R11: Register writes and reads work correctly while the internal-clock inhibit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_re | input | 1 | Read cycle active |
| reg_rdata | output | 8 | Read data |
| reg_rdata_oe | output | 1 | Enable for the processor data bus driver |
| gclk_core | output | 1 | Gated internal core clock |
| gclk_pal | output | 1 | Palette and cursor access clock, never gated |
| gclk_sclkgen | output | 1 | Gated SCLK generator clock |
| gclk_dotgen | output | 1 | Gated dot-clock generator clock |
| gclk_sync | output | 1 | Gated sync delay clock |
| sclk_oe | output | 1 | SCLK driver enable |
| dotclk_oe | output | 1 | Dot-clock driver enable |
| sense_oe | output | 1 | SENSE driver enable |
| hsync_in | input | 1 | Horizontal sync from the sync delay circuit |
| vsync_in | input | 1 | Vertical sync from the sync delay circuit |
| hsync_out | output | 1 | Horizontal sync output value |
| hsync_oe | output | 1 | Horizontal sync driver enable |
| vsync_out | output | 1 | Vertical sync output value |
| vsync_oe | output | 1 | Vertical sync driver enable |
| pix_in | input | PIX_W | Pixel data bound for the DAC |
| dac_data | output | PIX_W | Pixel data presented to the DAC |
| dac_pd | output | 1 | DAC analog power-down |

## Verification
The hardest case to reach from the ports is the frozen DAC path. The inhibit bit is written on the same edge at which the DAC register still loads. A pixel value set up before that write must therefore be captured, and a value applied afterwards must not be.

The stimulus sets one pixel value before the inhibit write and a different value after it. It waits several cycles and performs a register write and readback while the inhibit is still set. It then clears the inhibit and checks that the second value appears only one edge after the clearing write.

The gated clocks are sampled in the middle of the high phase. A stopped clock therefore reads 0 there and a running clock reads 1.

// File: rtl/dpwr_gate.sv
`timescale 1ns/1ps
module dpwr_gate #(
  parameter int         PIX_W    = 8,
  parameter logic [7:0] IDX_CLK  = 8'h02,
  parameter logic [7:0] IDX_SYNC = 8'h03,
  parameter logic [7:0] IDX_PWR  = 8'h05,
  parameter logic [7:0] IDX_MISC = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_we,
  input  logic             reg_re,
  output logic [7:0]       reg_rdata,
  output logic             reg_rdata_oe,
  output logic             gclk_core,
  output logic             gclk_pal,
  output logic             gclk_sclkgen,
  output logic             gclk_dotgen,
  output logic             gclk_sync,
  output logic             sclk_oe,
  output logic             dotclk_oe,
  output logic             sense_oe,
  input  logic             hsync_in,
  input  logic             vsync_in,
  output logic             hsync_out,
  output logic             hsync_oe,
  output logic             vsync_out,
  output logic             vsync_oe,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] dac_data,
  output logic             dac_pd
);

  logic [4:0] pwr_q;
  logic [1:0] clkdrv_q;
  logic [3:0] sync_q;
  logic       misc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= '0;
      clkdrv_q <= '0;
      sync_q   <= '0;
      misc_q   <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == IDX_PWR)  pwr_q    <= reg_wdata[4:0];
      if (reg_addr == IDX_CLK)  clkdrv_q <= reg_wdata[1:0];
      if (reg_addr == IDX_SYNC) sync_q   <= reg_wdata[3:0];
      if (reg_addr == IDX_MISC) misc_q   <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == IDX_PWR)  reg_rdata = {3'b000, pwr_q};
    if (reg_addr == IDX_CLK)  reg_rdata = {6'b0, clkdrv_q};
    if (reg_addr == IDX_SYNC) reg_rdata = {4'b0, sync_q};
    if (reg_addr == IDX_MISC) reg_rdata = {7'b0, misc_q};
  end
  assign reg_rdata_oe = reg_re;

  // gate order: core, sclk generator, dot generator, sync circuits
  logic [3:0] en_req, en_lat;
  assign en_req = {~pwr_q[2], ~pwr_q[1], ~pwr_q[0], ~pwr_q[3]};

  always_latch begin
    if (!clk) en_lat = en_req;
  end

  assign gclk_core    = clk & en_lat[0];
  assign gclk_sclkgen = clk & en_lat[1];
  assign gclk_dotgen  = clk & en_lat[2];
  assign gclk_sync    = clk & en_lat[3];
  assign gclk_pal     = clk;

  assign sclk_oe   = ~clkdrv_q[0];
  assign dotclk_oe = ~clkdrv_q[1];
  assign sense_oe  = ~misc_q;
  assign dac_pd    = pwr_q[4];

  function automatic logic [1:0] sync_drive(input logic [1:0] mode, input logic s);
    case (mode)
      2'b00:   return {1'b1, s};
      2'b01:   return 2'b11;
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  assign {hsync_oe, hsync_out} = sync_drive(sync_q[1:0], hsync_in);
  assign {vsync_oe, vsync_out} = sync_drive(sync_q[3:2], vsync_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_data <= '0;
    else if (!pwr_q[3]) dac_data <= pix_in;
  end

endmodule

module dpwr_gate_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             reg_we,
  input logic             reg_re,
  input logic [7:0]       reg_rdata,
  input logic [4:0]       pwr_q,
  input logic [3:0]       sync_q,
  input logic             hsync_out,
  input logic             hsync_oe,
  input logic             vsync_oe,
  input logic [PIX_W-1:0] dac_data
);
  // R8
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q[3] |=> $stable(dac_data));
  // R11
  pwr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h05) |=> (pwr_q == $past(reg_wdata[4:0])));
  // R2
  pwr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == 8'h05) |-> (reg_rdata == {3'b000, pwr_q}));
  // R10
  hsync_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1:0] == 2'b01) |-> (hsync_out && hsync_oe));
  // R10
  vsync_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[3:2] == 2'b11) |-> !vsync_oe);
endmodule

bind dpwr_gate dpwr_gate_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .pwr_q(pwr_q),
  .sync_q(sync_q), .hsync_out(hsync_out), .hsync_oe(hsync_oe),
  .vsync_oe(vsync_oe), .dac_data(dac_data)
);

// File: tb/dpwr_gate_bench.sv
`timescale 1ns/1ps
module dpwr_gate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, reg_re = 1'b0, reg_rdata_oe;
  logic gclk_core, gclk_pal, gclk_sclkgen, gclk_dotgen, gclk_sync;
  logic sclk_oe, dotclk_oe, sense_oe;
  logic hsync_in = 1'b0, vsync_in = 1'b0, hsync_out, hsync_oe, vsync_out, vsync_oe;
  logic [7:0] pix_in = '0, dac_data;
  logic dac_pd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpwr_gate u_dpwr_gate (.*);

  // {sync ctl[3:0], hsync_in, vsync_in, hsync_out, hsync_oe, vsync_out, vsync_oe}
  localparam logic [9:0] VEC [8] = '{
    10'b0000_10_1101, 10'b0000_01_0111, 10'b0101_00_1111, 10'b1010_11_0101,
    10'b1111_11_0000, 10'b0110_01_0111, 10'b1001_00_1101, 10'b1100_10_1100
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1; #1;
    d = reg_rdata;
    chk("R3 oe during read", {31'b0, reg_rdata_oe}, 32'd1);
    reg_re = 1'b0; #0.5;
    chk("R3 oe after read", {31'b0, reg_rdata_oe}, 32'd0);
  endtask

  // expected running mask {core, sclk, dot, sync, pal}
  task automatic clks(input string r, input logic [4:0] exp);
    @(posedge clk); #1;
    chk(r, {27'b0, gclk_core, gclk_sclkgen, gclk_dotgen, gclk_sync, gclk_pal}, {27'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {24'b0, reg_rdata_oe, sclk_oe, dotclk_oe, sense_oe, dac_pd, dac_data[2:0]}, {24'b0, 8'b0_111_0_000});
    rst_n = 1'b1;
    rd(8'h05, d); chk("R1 pwr reg", d, 0);
    rd(8'h03, d); chk("R1 sync reg", d, 0);
    clks("R1 clocks running", 5'b11111);

    for (int i = 0; i < 8; i++) begin
      wr(8'h03, {4'b0, VEC[i][9:6]});
      hsync_in = VEC[i][5]; vsync_in = VEC[i][4]; #1;
      chk("R10 sync vector", {28'b0, hsync_out, hsync_oe, vsync_out, vsync_oe}, {28'b0, VEC[i][3:0]});
    end
    wr(8'h03, 8'h00);

    // R2 map, undefined bits, unmapped index
    wr(8'h70, 8'hFF); rd(8'h70, d); chk("R2 misc bits", d, 8'h01);
    chk("R9 sense_oe", {31'b0, sense_oe}, 0);
    wr(8'h02, 8'hFD); rd(8'h02, d); chk("R2 clk reg bits", d, 8'h01);
    chk("R9 sclk/dot oe", {30'b0, sclk_oe, dotclk_oe}, 32'b01);
    wr(8'h02, 8'h02); chk("R9 dot disabled", {30'b0, sclk_oe, dotclk_oe}, 32'b10);
    rd(8'h04, d); chk("R2 unmapped read", d, 0);
    wr(8'h05, 8'hF0); rd(8'h05, d); chk("R2 pwr reg bits", d, 8'h10);
    chk("R4 dac_pd", {31'b0, dac_pd}, 1);
    wr(8'h05, 8'h00);

    // R6 individual stops, R7 resting low and timing
    wr(8'h05, 8'h01); clks("R6 sclk stop", 5'b10111);
    wr(8'h05, 8'h02); clks("R6 dot stop", 5'b11011);
    wr(8'h05, 8'h04); clks("R6 sync stop", 5'b11101);
    wr(8'h05, 8'h00); clks("R7 restart on first high phase", 5'b11111);
    // R5 inhibit stops only core
    wr(8'h05, 8'h08); clks("R5 inhibit", 5'b01111);

    // R8 DAC hold, R11 access under inhibit
    wr(8'h05, 8'h00);
    pix_in = 8'hA5; @(negedge clk); chk("R8 follow", dac_data, 8'hA5);
    pix_in = 8'h11; wr(8'h05, 8'h08); chk("R8 load at inhibit edge", dac_data, 8'h11);
    pix_in = 8'h22; repeat (3) @(negedge clk); chk("R8 hold", dac_data, 8'h11);
    wr(8'h03, 8'h05); rd(8'h03, d); chk("R11 write under inhibit", d, 8'h05);
    wr(8'h05, 8'h00); chk("R8 still held at clear edge", dac_data, 8'h11);
    @(negedge clk); chk("R8 resumes", dac_data, 8'h22);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule